// File: doc/BRIEF.md
# Far Return / Interrupt Return Frame Unwinder

This block unwinds the stack frame left behind by a far call or an interrupt so that a processor core can resume at the caller. On a start pulse it captures the stack pointer, the stack base, the operand size, whether the return is an interrupt return, the immediate byte count of a far return, and whether the return crosses to an outer privilege level. It then reads the frame item by item through a single read port. Each read is addressed at base plus the pointer under the stack mask, so a small stack wraps inside 64 KiB.

The read order depends on the kind of return. The code offset and the code selector always come first, and the flags word follows only for an interrupt return. After that the block takes one of three paths. A 32-bit interrupt return whose popped flags carry the virtual-8086 bit reads six more items. An outer-level return first skips the immediate byte count and then reads the outer stack pointer and stack selector. A same-level return only skips the immediate byte count.

Two frame checks can abort the sequence: a null code selector, and an outer stack selector whose requested privilege differs from that of the code selector. A completed or aborted sequence is reported by a one-cycle done pulse. All results are valid in that cycle and stay unchanged until the next completed sequence.

Top module: `retpop_seq`

## Requirements
- R1: Each read goes to memAddr = stackBase + (pointer AND mask), where mask is 0xFFFFFFFF when stackBig=1 and 0x0000FFFF when stackBig=0. The pointer starts at espIn and grows by 4 after each read when opSize32=1, and by 2 otherwise. memReq stays high with an unchanged memAddr until memValid is seen.
- R2: The frame is read in the order offset, code selector, then flags only when isIret=1. A 16-bit read uses memRdata[15:0] zero-extended. Selectors keep only their low 16 bits.
- R3: On the same-level and outer-level paths, retAddend (a byte count, zero-extended) is added to the pointer after the offset, selector and flags reads and before any later read.
- R4: With privChange=1 on a non-virtual-8086 return, the outer stack pointer is read and then the outer stack selector. stackSwitch=1, and newEsp = (espIn AND NOT mask) OR (popped pointer AND mask).
- R5: On a same-level return, newEsp = (espIn AND NOT mask) OR (final pointer AND mask), with stackSwitch=0 and newSs=0.
- R6: When opSize32=1, isIret=1 and bit 17 of the popped flags is 1, the block reads stack pointer, stack selector, ES, DS, FS and GS in that order, and adds no immediate. It then sets vmReturn=1, stackSwitch=1, newCpl=3, newEsp to the full popped value, and each selector to its low 16 bits.
- R7: On a non-virtual-8086 return whose popped code selector has bits 15:2 all zero, the sequence aborts with fault=1 and faultCode=1, and no further read is issued.
- R8: On an outer-level return whose popped stack selector bits 1:0 differ from the code selector bits 1:0, the sequence aborts with fault=1 and faultCode=2.
- R9: An aborted sequence pulses done and fault together for one cycle and leaves every result output at its previous value.
- R10: A completed sequence pulses done for one cycle with fault=0 and faultCode=0. In that same cycle every result is valid, and the results are held until the next completion. On a non-virtual-8086 return newCpl equals the code selector bits 1:0. newEflags is the popped flags for an interrupt return and 0 for a far return. Unused selectors and newSs read 0.
- R11: A start pulse while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin unwinding a frame |
| opSize32 | input | 1 | 1: 32-bit items, 0: 16-bit items |
| isIret | input | 1 | Interrupt return (flags word present) |
| privChange | input | 1 | Return goes to an outer privilege level |
| stackBig | input | 1 | 1: 32-bit stack pointer mask, 0: 16-bit |
| stackBase | input | 32 | Linear base of the stack segment |
| espIn | input | 32 | Stack pointer at the start |
| retAddend | input | 16 | Immediate byte count of a far return |
| memReq | output | 1 | Read request |
| memAddr | output | 32 | Read address |
| memValid | input | 1 | Read data valid; accepts the request |
| memRdata | input | 32 | Read data |
| done | output | 1 | Sequence finished (one cycle) |
| fault | output | 1 | Sequence aborted by a frame check |
| faultCode | output | 2 | 1 null code selector, 2 stack selector privilege mismatch |
| newEip | output | 32 | Return offset |
| newCs | output | 16 | Return code selector |
| newEflags | output | 32 | Popped flags (interrupt return) |
| newEsp | output | 32 | Stack pointer to commit |
| newSs | output | 16 | Stack selector to load |
| newEs | output | 16 | ES selector on virtual-8086 return |
| newDs | output | 16 | DS selector on virtual-8086 return |
| newFs | output | 16 | FS selector on virtual-8086 return |
| newGs | output | 16 | GS selector on virtual-8086 return |
| newCpl | output | 2 | Privilege level after the return |
| stackSwitch | output | 1 | newSs/newEsp come from the frame |
| vmReturn | output | 1 | Return enters virtual-8086 mode |

## Verification
The frame is unwound as a 32-bit and a 16-bit far return, as same-level and outer-level interrupt returns, and as a virtual-8086 interrupt return. Comparing the read addresses across these cases separates the three paths and shows where the immediate is applied. A 16-bit stack placed just below 64 KiB tells masked wrapping apart from plain 32-bit growth, and a nonzero upper half of espIn shows that the committed pointer merges under the mask. A null selector and a mismatched stack selector drive the two abort paths, and a stray start pulse in mid-sequence tests that the captured operands cannot be disturbed. Read latency varies from zero to three cycles.

// File: rtl/retpop_pkg.sv
package retpop_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_EIP, S_CS, S_FL, S_HDR,
    S_OESP, S_OSS,
    S_VESP, S_VSS, S_VES, S_VDS, S_VFS, S_VGS,
    S_FIN
  } seqState_t;

  typedef enum logic [3:0] {
    IT_EIP, IT_CS, IT_FL, IT_ESP, IT_SS, IT_ES, IT_DS, IT_FS, IT_GS
  } item_t;

  localparam int NUM_ITEMS = 9;

  localparam logic [1:0] FC_NONE    = 2'd0;
  localparam logic [1:0] FC_NULL_CS = 2'd1;
  localparam logic [1:0] FC_SS_RPL  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       popEn;
    item_t      popItem;
    logic       addAddend;
    logic       commit;
    logic       abort;
    logic [1:0] abortCode;
    logic       vmPath;
    logic       outerPath;
    logic       flagsValid;
  } seqCtl_t;

  // frame conditions from datapath to control
  typedef struct packed {
    logic csNull;
    logic flVm;
    logic ssRplBad;
  } dpStat_t;

endpackage

// File: rtl/retpop_ctrl.sv
module retpop_ctrl
  import retpop_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    opSize32,
  input  logic    isIret,
  input  logic    privChange,
  input  logic    memValid,
  input  dpStat_t stat,
  output seqCtl_t ctl,
  output logic    memReq
);

  seqState_t state, stateNx;
  logic op32Q, iretQ, privQ, vmQ;
  logic vmNow;

  function automatic item_t itemOf(seqState_t s);
    case (s)
      S_EIP:         return IT_EIP;
      S_CS:          return IT_CS;
      S_FL:          return IT_FL;
      S_OESP, S_VESP: return IT_ESP;
      S_OSS, S_VSS:  return IT_SS;
      S_VES:         return IT_ES;
      S_VDS:         return IT_DS;
      S_VFS:         return IT_FS;
      default:       return IT_GS;
    endcase
  endfunction

  function automatic logic isPop(seqState_t s);
    return !(s == S_IDLE || s == S_HDR || s == S_FIN);
  endfunction

  assign vmNow  = iretQ & op32Q & stat.flVm;
  assign memReq = isPop(state);

  always_comb begin
    stateNx        = state;
    ctl            = '0;
    ctl.popItem    = itemOf(state);
    ctl.vmPath     = vmQ;
    ctl.outerPath  = privQ & ~vmQ;
    ctl.flagsValid = iretQ;
    case (state)
      S_IDLE: if (start) begin
        ctl.load = 1'b1;
        stateNx  = S_EIP;
      end
      S_HDR: begin
        if (vmNow) begin
          stateNx = S_VESP;
        end else if (stat.csNull) begin
          ctl.abort     = 1'b1;
          ctl.abortCode = FC_NULL_CS;
          stateNx       = S_IDLE;
        end else begin
          ctl.addAddend = 1'b1;
          stateNx       = privQ ? S_OESP : S_FIN;
        end
      end
      S_FIN: begin
        if (privQ && !vmQ && stat.ssRplBad) begin
          ctl.abort     = 1'b1;
          ctl.abortCode = FC_SS_RPL;
        end else begin
          ctl.commit = 1'b1;
        end
        stateNx = S_IDLE;
      end
      default: if (memValid) begin
        ctl.popEn = 1'b1;
        case (state)
          S_EIP:   stateNx = S_CS;
          S_CS:    stateNx = iretQ ? S_FL : S_HDR;
          S_FL:    stateNx = S_HDR;
          S_OESP:  stateNx = S_OSS;
          S_VESP:  stateNx = S_VSS;
          S_VSS:   stateNx = S_VES;
          S_VES:   stateNx = S_VDS;
          S_VDS:   stateNx = S_VFS;
          S_VFS:   stateNx = S_VGS;
          default: stateNx = S_FIN;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      op32Q <= 1'b0;
      iretQ <= 1'b0;
      privQ <= 1'b0;
      vmQ   <= 1'b0;
    end else begin
      state <= stateNx;
      if (ctl.load) begin
        op32Q <= opSize32;
        iretQ <= isIret;
        privQ <= privChange;
        vmQ   <= 1'b0;
      end else if (state == S_HDR && vmNow) begin
        vmQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/retpop_dp.sv
module retpop_dp
  import retpop_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              opSize32,
  input  logic              stackBig,
  input  logic [WORD_W-1:0] stackBase,
  input  logic [WORD_W-1:0] espIn,
  input  logic [IMM_W-1:0]  retAddend,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output dpStat_t           stat,
  output logic              done,
  output logic              fault,
  output logic [1:0]        faultCode,
  output logic [WORD_W-1:0] newEip,
  output logic [SEL_W-1:0]  newCs,
  output logic [WORD_W-1:0] newEflags,
  output logic [WORD_W-1:0] newEsp,
  output logic [SEL_W-1:0]  newSs,
  output logic [SEL_W-1:0]  newEs,
  output logic [SEL_W-1:0]  newDs,
  output logic [SEL_W-1:0]  newFs,
  output logic [SEL_W-1:0]  newGs,
  output logic [1:0]        newCpl,
  output logic              stackSwitch,
  output logic              vmReturn
);

  localparam int SEL_W   = WORD_W / 2;
  localparam int VM_BIT  = 17;
  localparam logic [WORD_W-1:0] STEP_BIG   = WORD_W'(4);
  localparam logic [WORD_W-1:0] STEP_SMALL = WORD_W'(2);

  logic              op32Q, bigQ;
  logic [WORD_W-1:0] baseQ, espQ, ptr, mask, popVal;
  logic [IMM_W-1:0]  addQ;
  logic [WORD_W-1:0] itemVal [NUM_ITEMS];

  assign mask    = bigQ ? '1 : {{(WORD_W-SEL_W){1'b0}}, {SEL_W{1'b1}}};
  assign memAddr = baseQ + (ptr & mask);
  assign popVal  = op32Q ? memRdata : {{(WORD_W-SEL_W){1'b0}}, memRdata[SEL_W-1:0]};

  // one staging register per frame item
  for (genvar i = 0; i < NUM_ITEMS; i++) begin : g_stg
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else if (ctl.popEn && ctl.popItem == item_t'(i)) q <= popVal;
    end
    assign itemVal[i] = q;
  end

  logic [WORD_W-1:0] eipV, csV, flV, espV, ssV;
  assign eipV = itemVal[IT_EIP];
  assign csV  = itemVal[IT_CS];
  assign flV  = itemVal[IT_FL];
  assign espV = itemVal[IT_ESP];
  assign ssV  = itemVal[IT_SS];

  assign stat.csNull   = (csV[SEL_W-1:2] == '0);
  assign stat.flVm     = flV[VM_BIT];
  assign stat.ssRplBad = (ssV[1:0] != csV[1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      op32Q <= 1'b0;
      bigQ  <= 1'b0;
      baseQ <= '0;
      espQ  <= '0;
      addQ  <= '0;
      ptr   <= '0;
    end else if (ctl.load) begin
      op32Q <= opSize32;
      bigQ  <= stackBig;
      baseQ <= stackBase;
      espQ  <= espIn;
      addQ  <= retAddend;
      ptr   <= espIn;
    end else if (ctl.popEn) begin
      ptr <= ptr + (op32Q ? STEP_BIG : STEP_SMALL);
    end else if (ctl.addAddend) begin
      ptr <= ptr + {{(WORD_W-IMM_W){1'b0}}, addQ};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      fault     <= 1'b0;
      faultCode <= FC_NONE;
    end else begin
      done      <= ctl.commit | ctl.abort;
      fault     <= ctl.abort;
      if (ctl.commit || ctl.abort) faultCode <= ctl.abort ? ctl.abortCode : FC_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newEip      <= '0;
      newCs       <= '0;
      newEflags   <= '0;
      newEsp      <= '0;
      newSs       <= '0;
      newEs       <= '0;
      newDs       <= '0;
      newFs       <= '0;
      newGs       <= '0;
      newCpl      <= '0;
      stackSwitch <= 1'b0;
      vmReturn    <= 1'b0;
    end else if (ctl.commit) begin
      newEip      <= eipV;
      newCs       <= csV[SEL_W-1:0];
      newEflags   <= ctl.flagsValid ? flV : '0;
      vmReturn    <= ctl.vmPath;
      stackSwitch <= ctl.vmPath | ctl.outerPath;
      newSs       <= (ctl.vmPath | ctl.outerPath) ? ssV[SEL_W-1:0] : '0;
      newEs       <= ctl.vmPath ? itemVal[IT_ES][SEL_W-1:0] : '0;
      newDs       <= ctl.vmPath ? itemVal[IT_DS][SEL_W-1:0] : '0;
      newFs       <= ctl.vmPath ? itemVal[IT_FS][SEL_W-1:0] : '0;
      newGs       <= ctl.vmPath ? itemVal[IT_GS][SEL_W-1:0] : '0;
      newCpl      <= ctl.vmPath ? 2'b11 : csV[1:0];
      if (ctl.vmPath)         newEsp <= espV;
      else if (ctl.outerPath) newEsp <= (espQ & ~mask) | (espV & mask);
      else                    newEsp <= (espQ & ~mask) | (ptr & mask);
    end
  end

endmodule

// File: rtl/retpop_seq.sv
module retpop_seq
  import retpop_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opSize32,
  input  logic              isIret,
  input  logic              privChange,
  input  logic              stackBig,
  input  logic [WORD_W-1:0] stackBase,
  input  logic [WORD_W-1:0] espIn,
  input  logic [IMM_W-1:0]  retAddend,
  output logic              memReq,
  output logic [WORD_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [WORD_W-1:0] memRdata,
  output logic              done,
  output logic              fault,
  output logic [1:0]        faultCode,
  output logic [WORD_W-1:0] newEip,
  output logic [WORD_W/2-1:0] newCs,
  output logic [WORD_W-1:0] newEflags,
  output logic [WORD_W-1:0] newEsp,
  output logic [WORD_W/2-1:0] newSs,
  output logic [WORD_W/2-1:0] newEs,
  output logic [WORD_W/2-1:0] newDs,
  output logic [WORD_W/2-1:0] newFs,
  output logic [WORD_W/2-1:0] newGs,
  output logic [1:0]        newCpl,
  output logic              stackSwitch,
  output logic              vmReturn
);

  seqCtl_t ctl;
  dpStat_t stat;

  retpop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opSize32(opSize32),
    .isIret(isIret), .privChange(privChange), .memValid(memValid),
    .stat(stat), .ctl(ctl), .memReq(memReq)
  );

  retpop_dp #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opSize32(opSize32),
    .stackBig(stackBig), .stackBase(stackBase), .espIn(espIn),
    .retAddend(retAddend), .memRdata(memRdata), .memAddr(memAddr),
    .stat(stat), .done(done), .fault(fault), .faultCode(faultCode),
    .newEip(newEip), .newCs(newCs), .newEflags(newEflags), .newEsp(newEsp),
    .newSs(newSs), .newEs(newEs), .newDs(newDs), .newFs(newFs), .newGs(newGs),
    .newCpl(newCpl), .stackSwitch(stackSwitch), .vmReturn(vmReturn)
  );

endmodule

// File: rtl/retpop_chk.sv
module retpop_chk #(
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                memReq,
  input logic                memValid,
  input logic [WORD_W-1:0]   memAddr,
  input logic                done,
  input logic                fault,
  input logic [1:0]          faultCode,
  input logic [WORD_W-1:0]   newEip,
  input logic [WORD_W/2-1:0] newCs,
  input logic [WORD_W-1:0]   newEsp,
  input logic [WORD_W/2-1:0] newSs,
  input logic [1:0]          newCpl,
  input logic                vmReturn
);

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));

  assert_fault_in_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> done && faultCode != 2'd0);

  assert_fault_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> $stable(newEip) && $stable(newCs) && $stable(newEsp) && $stable(newSs));

  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(newEip) && $stable(newCs) && $stable(newEsp) && $stable(newCpl));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_vm_cpl3_R6: assert property (@(posedge clk) disable iff (!rstN)
    done && !fault && vmReturn |-> newCpl == 2'b11);

  assert_cpl_rpl_R10: assert property (@(posedge clk) disable iff (!rstN)
    done && !fault && !vmReturn |-> newCpl == newCs[1:0]);

  assert_cs_nonnull_R7: assert property (@(posedge clk) disable iff (!rstN)
    done && !fault && !vmReturn |-> newCs[WORD_W/2-1:2] != '0);

  assert_no_read_at_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

endmodule

bind retpop_seq retpop_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memValid(memValid),
  .memAddr(memAddr), .done(done), .fault(fault), .faultCode(faultCode),
  .newEip(newEip), .newCs(newCs), .newEsp(newEsp), .newSs(newSs),
  .newCpl(newCpl), .vmReturn(vmReturn)
);

// File: tb/retpop_seq_tb.sv
module retpop_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, opSize32 = 1'b0, isIret = 1'b0, privChange = 1'b0, stackBig = 1'b0;
  logic [31:0] stackBase = '0, espIn = '0;
  logic [15:0] retAddend = '0;
  logic        memReq, memValid = 1'b0;
  logic [31:0] memAddr, memRdata = '0;
  logic        done, fault, stackSwitch, vmReturn;
  logic [1:0]  faultCode, newCpl;
  logic [31:0] newEip, newEflags, newEsp;
  logic [15:0] newCs, newSs, newEs, newDs, newFs, newGs;

  always #(CLK_PERIOD/2) clk = ~clk;

  retpop_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSize32(opSize32), .isIret(isIret),
    .privChange(privChange), .stackBig(stackBig), .stackBase(stackBase),
    .espIn(espIn), .retAddend(retAddend), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memRdata(memRdata), .done(done), .fault(fault),
    .faultCode(faultCode), .newEip(newEip), .newCs(newCs), .newEflags(newEflags),
    .newEsp(newEsp), .newSs(newSs), .newEs(newEs), .newDs(newDs), .newFs(newFs),
    .newGs(newGs), .newCpl(newCpl), .stackSwitch(stackSwitch), .vmReturn(vmReturn)
  );

  int nChecks = 0, nFails = 0;
  logic [7:0]  mem [logic [31:0]];
  logic [31:0] expAddr [$];
  int          latency = 0, latCnt = 0;
  bit          expPending = 0, doneSeen = 0, checking = 0;
  string       curReq = "R2";

  // expected results of the pending sequence and held results
  logic        eFault; logic [1:0] eCode;
  logic [31:0] eEip, eFl, eEsp, hEip, hFl, hEsp;
  logic [15:0] eCs, eSs, eEs, eDs, eFs, eGs, hCs, hSs, hEs, hDs, hFs, hGs;
  logic [1:0]  eCpl, hCpl;
  logic        eSw, eVm, hSw, hVm;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rdMem(logic [31:0] a, int nBytes);
    logic [31:0] v = '0;
    for (int k = 0; k < nBytes; k++)
      if (mem.exists(a + k)) v[8*k +: 8] = mem[a + k];
    return v;
  endfunction

  task automatic wrMem(logic [31:0] a, logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[a + k] = v[8*k +: 8];
  endtask

  // place items at consecutive slots starting at pointer p
  task automatic place(logic [31:0] base, logic [31:0] p, bit big, bit w32,
                       logic [31:0] items [$]);
    logic [31:0] m = big ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    foreach (items[k]) wrMem(base + ((p + k * (w32 ? 4 : 2)) & m), items[k]);
  endtask

  // behavioural reference of one unwind
  task automatic model();
    logic [31:0] m = stackBig ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [31:0] sp = espIn;
    int          w = opSize32 ? 4 : 2;
    logic [31:0] v [9];
    int          n = 0;
    expAddr.delete();
    eFault = 0; eCode = 0;
    for (int k = 0; k < 9; k++) v[k] = '0;
    v[0] = rdMem(stackBase + (sp & m), w); expAddr.push_back(stackBase + (sp & m)); sp += w;
    v[1] = rdMem(stackBase + (sp & m), w); expAddr.push_back(stackBase + (sp & m)); sp += w;
    if (isIret) begin
      v[2] = rdMem(stackBase + (sp & m), w); expAddr.push_back(stackBase + (sp & m)); sp += w;
    end
    eEip = v[0]; eCs = v[1][15:0]; eFl = isIret ? v[2] : '0;
    eSs = 0; eEs = 0; eDs = 0; eFs = 0; eGs = 0;
    if (isIret && opSize32 && v[2][17]) begin
      for (int k = 3; k < 9; k++) begin
        v[k] = rdMem(stackBase + (sp & m), 4); expAddr.push_back(stackBase + (sp & m)); sp += 4;
      end
      eEsp = v[3]; eSs = v[4][15:0]; eEs = v[5][15:0]; eDs = v[6][15:0];
      eFs = v[7][15:0]; eGs = v[8][15:0]; eCpl = 2'b11; eSw = 1; eVm = 1;
    end else if (eCs[15:2] == 0) begin
      eFault = 1; eCode = 2'd1;
    end else begin
      sp += {16'h0, retAddend};
      eVm = 0; eCpl = eCs[1:0]; eSw = privChange;
      if (privChange) begin
        v[3] = rdMem(stackBase + (sp & m), w); expAddr.push_back(stackBase + (sp & m)); sp += w;
        v[4] = rdMem(stackBase + (sp & m), w); expAddr.push_back(stackBase + (sp & m)); sp += w;
        eSs  = v[4][15:0];
        eEsp = (espIn & ~m) | (v[3] & m);
        if (eSs[1:0] != eCs[1:0]) begin eFault = 1; eCode = 2'd2; end
      end else begin
        eEsp = (espIn & ~m) | (sp & m);
      end
    end
    n = n;
  endtask

  task automatic cmpHeld(string req);
    chk({req, " eip"},  newEip, hEip);
    chk({req, " cs"},   {16'h0, newCs}, {16'h0, hCs});
    chk({req, " fl"},   newEflags, hFl);
    chk({req, " esp"},  newEsp, hEsp);
    chk({req, " ss"},   {16'h0, newSs}, {16'h0, hSs});
    chk({req, " es"},   {16'h0, newEs}, {16'h0, hEs});
    chk({req, " ds"},   {16'h0, newDs}, {16'h0, hDs});
    chk({req, " fs"},   {16'h0, newFs}, {16'h0, hFs});
    chk({req, " gs"},   {16'h0, newGs}, {16'h0, hGs});
    chk({req, " cpl"},  {30'h0, newCpl}, {30'h0, hCpl});
    chk({req, " sw"},   {31'h0, stackSwitch}, {31'h0, hSw});
    chk({req, " vm"},   {31'h0, vmReturn}, {31'h0, hVm});
  endtask

  // memory responder and per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      if (done) begin
        if (!expPending) chk("R10 unexpected done", 32'd1, 32'd0);
        else begin
          chk({curReq, " fault"}, {31'h0, fault}, {31'h0, eFault});
          chk({curReq, " code"}, {30'h0, faultCode}, {30'h0, eCode});
          chk("R7 reads left", expAddr.size(), 0);
          if (!eFault) begin
            hEip = eEip; hCs = eCs; hFl = eFl; hEsp = eEsp; hSs = eSs; hEs = eEs;
            hDs = eDs; hFs = eFs; hGs = eGs; hCpl = eCpl; hSw = eSw; hVm = eVm;
          end
          cmpHeld(eFault ? "R9" : curReq);
          expPending = 0;
          doneSeen = 1;
        end
      end else begin
        cmpHeld("R10 hold");
      end
    end
    if (memValid) begin
      memValid <= 1'b0;
      latCnt = latency;
    end else if (memReq) begin
      if (latCnt == 0) begin
        if (expAddr.size() == 0) chk("R1 extra read", memAddr, 32'hXXXX_XXXX);
        else chk({curReq, " R1 addr"}, memAddr, expAddr.pop_front());
        memRdata <= rdMem(memAddr, 4);
        memValid <= 1'b1;
      end else latCnt--;
    end
  end

  task automatic runCase(string req, bit o32, bit iret, bit priv, bit big,
                         logic [31:0] base, logic [31:0] esp, logic [15:0] add,
                         int lat, bit intrude);
    @(negedge clk);
    opSize32 = o32; isIret = iret; privChange = priv; stackBig = big;
    stackBase = base; espIn = esp; retAddend = add; latency = lat; latCnt = lat;
    curReq = req;
    model();
    expPending = 1; doneSeen = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (2) @(negedge clk);
      espIn = 32'h0BAD_0000; isIret = ~isIret; opSize32 = ~opSize32; retAddend = 16'h0100;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 200 && !doneSeen; t++) @(negedge clk);
    if (!doneSeen) chk({req, " no done"}, 32'd0, 32'd1);
    @(negedge clk);
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishUp();
  end

  initial begin
    hEip = 0; hCs = 0; hFl = 0; hEsp = 0; hSs = 0; hEs = 0; hDs = 0;
    hFs = 0; hGs = 0; hCpl = 0; hSw = 0; hVm = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R10)
    chk("R10 reset done", {31'h0, done}, 32'h0);
    chk("R1 reset memReq", {31'h0, memReq}, 32'h0);
    cmpHeld("R10 reset");
    checking = 1;

    // R2 R3 R5: 32-bit far return, same level, immediate 8
    place(32'h0001_0000, 32'h0000_2000, 1, 1, '{32'h0040_1000, 32'hBEEF_001B});
    runCase("R3", 1, 0, 0, 1, 32'h0001_0000, 32'h0000_2000, 16'd8, 0, 0);

    // R1 R5: 16-bit far return on a small stack that wraps at 64 KiB
    place(32'h0002_0000, 32'hABCD_FFFE, 0, 0, '{32'h0000_1234, 32'h0000_0048});
    runCase("R1", 0, 0, 0, 0, 32'h0002_0000, 32'hABCD_FFFE, 16'd4, 1, 0);

    // R2 R10: 32-bit interrupt return, same level
    place(32'h0003_0000, 32'h0000_3000, 1, 1, '{32'h0000_8000, 32'h0000_0010, 32'h0000_0202});
    runCase("R2", 1, 1, 0, 1, 32'h0003_0000, 32'h0000_3000, 16'd0, 2, 0);

    // R4: 16-bit interrupt return to an outer level
    place(32'h0004_0000, 32'h0000_0100, 0, 0,
          '{32'h0000_0555, 32'h0000_002B, 32'h0000_0246, 32'h0000_7FF0, 32'h0000_0033});
    runCase("R4", 0, 1, 1, 0, 32'h0004_0000, 32'h0000_0100, 16'd0, 1, 0);

    // R3 R4: 32-bit far return to outer level with immediate 12, small stack
    place(32'h0005_0000, 32'h5555_FFF0, 0, 1, '{32'h0000_9999, 32'h0000_0023});
    place(32'h0005_0000, 32'h5555_FFF0 + 8 + 12, 0, 1, '{32'h1234_5678, 32'hFFFF_002B});
    runCase("R4", 1, 0, 1, 0, 32'h0005_0000, 32'h5555_FFF0, 16'd12, 0, 0);

    // R6: virtual-8086 interrupt return, immediate must be ignored
    place(32'h0006_0000, 32'h0000_4000, 1, 1,
          '{32'h0000_0100, 32'hDEAD_F000, 32'h0002_0202, 32'h0000_FFEE,
            32'h1234_0800, 32'hAAAA_1000, 32'hBBBB_2000, 32'hCCCC_3000, 32'hDDDD_4000});
    runCase("R6", 1, 1, 0, 1, 32'h0006_0000, 32'h0000_4000, 16'd0, 3, 0);

    // R7: null code selector aborts after the selector read
    place(32'h0007_0000, 32'h0000_5000, 1, 1, '{32'h0000_7777, 32'h0000_0002});
    runCase("R7", 1, 0, 1, 1, 32'h0007_0000, 32'h0000_5000, 16'd0, 1, 0);

    // R8: outer stack selector privilege mismatch
    place(32'h0008_0000, 32'h0000_6000, 1, 1,
          '{32'h0000_6666, 32'h0000_0023, 32'h0000_9000, 32'h0000_0028});
    runCase("R8", 1, 0, 1, 1, 32'h0008_0000, 32'h0000_6000, 16'd0, 0, 0);

    // R11: stray start in mid-sequence
    place(32'h0009_0000, 32'h0000_7000, 1, 1, '{32'h0000_4321, 32'h0000_0019});
    runCase("R11", 1, 0, 0, 1, 32'h0009_0000, 32'h0000_7000, 16'd2, 3, 1);

    // R2 R5: 16-bit far return on a big stack, no immediate
    place(32'h000A_0000, 32'h0001_FFFE, 1, 0, '{32'h0000_ABCD, 32'h0000_0031});
    runCase("R2", 0, 0, 0, 1, 32'h000A_0000, 32'h0001_FFFE, 16'd0, 2, 0);

    // R10: results unchanged while idle
    repeat (5) @(negedge clk);
    cmpHeld("R10 idle");
    checking = 0;
    finishUp();
  end

endmodule